// File: doc/BRIEF.md
# Queue Doorbell Register Decoder

This block sits on the write side of a memory-mapped register window. A host moves a queue forward with one 32-bit store: a new tail index for a submission queue, or a new head index for a completion queue. The block finds out which queue and which side the store names. If the index is legal it keeps the index and sends a notification to the command engine. It also serves reads of the pointers it holds and of the capability bits that describe the doorbell layout.

Doorbells start at byte offset 0x1000. Each queue has a pair of slots, submission first and completion second, and neighbouring slots sit one stride apart. The stride is set by a 4-bit selector, `DSTRD`, which is fixed when the block is built and can be read back by software. A store that misses every doorbell is dropped and raises a sticky address error. So is a store that names a queue the block does not implement. A store whose index is too large for the queue depth is dropped and raises a sticky value error.

Top module: `dbell_decoder`

## Requirements
- R1: After reset, every stored pointer reads as 0. `notifyValid`, `rdValid`, `addrErr` and `valErr` are all 0.
- R2: A write to byte offset 0x1000 + 2·y·S stores the index for the submission queue of queue y. S is the byte stride. The index must be below `QDEPTH`, and y must be below `QUEUES`. On the cycle after the write, the block gives one `notifyValid` pulse with `notifyQid`=y, `notifyIsCq`=0 and `notifyPtr` equal to the index.
- R3: A write to byte offset 0x1000 + (2·y+1)·S does the same for the completion-queue head of queue y, with `notifyIsCq`=1.
- R4: The byte stride S equals 4 << `DSTRD`. A read of offset 4 returns `DSTRD` in bits 3:0, which are bits 35:32 of the 64-bit capability word at offset 0. A read of offset 0 returns `QDEPTH`-1 in its low bits.
- R5: A write at or above 0x1000 whose offset from 0x1000 is not a multiple of S stores nothing and sends no notification. It sets `addrErr`.
- R6: A write that lands on a slot of a queue y ≥ `QUEUES` stores nothing and sends no notification. It sets `addrErr`.
- R7: A doorbell write whose 32-bit data is ≥ `QDEPTH` leaves the stored pointer unchanged and sends no notification. It sets `valErr`.
- R8: A write below offset 0x1000 has no effect on the pointers, the notification or the error flags.
- R9: When `rdEn` is high at a clock edge, `rdValid` is high for the next cycle and `rdData` holds the value read. For a valid doorbell address, `rdData` is the stored pointer as it stood before that edge. For any other address except 0 and 4, `rdData` is 0.
- R10: Once `addrErr` or `valErr` is set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write byte offset in the window |
| wrData | input | 32 | Write data (new index) |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read byte offset |
| rdData | output | 32 | Read data, one cycle after rdEn |
| rdValid | output | 1 | Read data valid |
| notifyValid | output | 1 | One-cycle pulse per accepted doorbell |
| notifyQid | output | QID_W | Queue of the accepted doorbell |
| notifyIsCq | output | 1 | 1 for a completion head, 0 for a submission tail |
| notifyPtr | output | PTR_W | Accepted index |
| addrErr | output | 1 | Sticky: doorbell-region write hit no doorbell |
| valErr | output | 1 | Sticky: written index at or above depth |

## Verification
Every result of this block is due exactly one clock after the rising edge that sampled the write or read. This covers the notification fields, the two error flags, `rdData` and `rdValid`. A pointer written at edge t can be seen by a read sampled at edge t+1 or later. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge from those inputs. It then compares every output against the model on the following falling edge, so each result is checked in the one cycle in which it is due. A read and a write to the same doorbell in the same cycle are checked for returning the old pointer.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  localparam logic [31:0] DB_BASE = 32'h0000_1000;

  // Decode of one byte offset against the doorbell grid
  typedef struct packed {
    logic        inRegion;
    logic        aligned;
    logic [31:0] slot;
  } dbSlot_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic isCq;
    logic addrErr;
    logic valErr;
    logic rdEn;
    logic rdPtr;
    logic rdIsCq;
    logic rdCapLo;
    logic rdCapHi;
  } dbStrobe_t;

  function automatic dbSlot_t slotOf(input logic [31:0] addr, input int unsigned strideSel);
    dbSlot_t     r;
    logic [31:0] rel;
    logic [31:0] mask;
    int unsigned sh;
    sh         = strideSel + 2;
    rel        = addr - DB_BASE;
    mask       = (32'd1 << sh) - 32'd1;
    r.inRegion = (addr >= DB_BASE);
    r.aligned  = ((rel & mask) == 32'd0);
    r.slot     = rel >> sh;
    return r;
  endfunction

endpackage

// File: rtl/dbell_ctrl.sv
module dbell_ctrl
  import dbell_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int QUEUES = 4,
  parameter int QDEPTH = 16,
  parameter int DSTRD  = 1,
  parameter int QID_W  = 2,
  parameter int PTR_W  = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output dbStrobe_t         strobe,
  output logic [QID_W-1:0]  wrQid,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [QID_W-1:0]  rdQid
);

  logic [31:0] wrAddr32, rdAddr32;
  dbSlot_t     wSlot, rSlot;
  logic [31:0] wQidFull, rQidFull;
  logic        wHit, rHit, wQidOk, rQidOk, depthOk;

  assign wrAddr32 = 32'(wrAddr);
  assign rdAddr32 = 32'(rdAddr);

  always_comb begin
    wSlot    = slotOf(wrAddr32, DSTRD);
    rSlot    = slotOf(rdAddr32, DSTRD);
    wQidFull = wSlot.slot >> 1;
    rQidFull = rSlot.slot >> 1;
    wQidOk   = (wQidFull < 32'(QUEUES));
    rQidOk   = (rQidFull < 32'(QUEUES));
    wHit     = wSlot.inRegion && wSlot.aligned && wQidOk;
    rHit     = rSlot.inRegion && rSlot.aligned && rQidOk;
    depthOk  = (wrData < 32'(QDEPTH));

    strobe.load    = wrEn && wHit && depthOk;
    strobe.isCq    = wSlot.slot[0];
    strobe.addrErr = wrEn && wSlot.inRegion && !(wSlot.aligned && wQidOk);
    strobe.valErr  = wrEn && wHit && !depthOk;
    strobe.rdEn    = rdEn;
    strobe.rdPtr   = rdEn && rHit;
    strobe.rdIsCq  = rSlot.slot[0];
    strobe.rdCapLo = rdEn && (rdAddr32 == 32'd0);
    strobe.rdCapHi = rdEn && (rdAddr32 == 32'd4);

    wrQid = wQidFull[QID_W-1:0];
    rdQid = rQidFull[QID_W-1:0];
    wrPtr = wrData[PTR_W-1:0];
  end

endmodule

// File: rtl/dbell_dpath.sv
module dbell_dpath
  import dbell_pkg::*;
#(
  parameter int QUEUES = 4,
  parameter int QDEPTH = 16,
  parameter int DSTRD  = 1,
  parameter int QID_W  = 2,
  parameter int PTR_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dbStrobe_t        strobe,
  input  logic [QID_W-1:0] wrQid,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [QID_W-1:0] rdQid,
  output logic [31:0]      rdData,
  output logic             rdValid,
  output logic             notifyValid,
  output logic [QID_W-1:0] notifyQid,
  output logic             notifyIsCq,
  output logic [PTR_W-1:0] notifyPtr,
  output logic             addrErr,
  output logic             valErr
);

  logic [PTR_W-1:0] sqTail [QUEUES];
  logic [PTR_W-1:0] cqHead [QUEUES];
  logic [31:0]      rdNext;

  // Pointer storage, one register pair per queue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int q = 0; q < QUEUES; q++) begin
        sqTail[q] <= '0;
        cqHead[q] <= '0;
      end
    end else if (strobe.load) begin
      for (int q = 0; q < QUEUES; q++) begin
        if (wrQid == QID_W'(q)) begin
          if (strobe.isCq) cqHead[q] <= wrPtr;
          else             sqTail[q] <= wrPtr;
        end
      end
    end
  end

  // Notification and sticky flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      notifyValid <= 1'b0;
      notifyQid   <= '0;
      notifyIsCq  <= 1'b0;
      notifyPtr   <= '0;
      addrErr     <= 1'b0;
      valErr      <= 1'b0;
    end else begin
      notifyValid <= strobe.load;
      if (strobe.load) begin
        notifyQid  <= wrQid;
        notifyIsCq <= strobe.isCq;
        notifyPtr  <= wrPtr;
      end
      addrErr <= addrErr | strobe.addrErr;
      valErr  <= valErr  | strobe.valErr;
    end
  end

  // Read-back mux
  always_comb begin
    rdNext = '0;
    if (strobe.rdCapLo)      rdNext = 32'(QDEPTH - 1);
    else if (strobe.rdCapHi) rdNext = 32'(DSTRD);
    else if (strobe.rdPtr)   rdNext = strobe.rdIsCq ? 32'(cqHead[rdQid]) : 32'(sqTail[rdQid]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/dbell_decoder.sv
module dbell_decoder
  import dbell_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int QUEUES = 4,
  parameter int QDEPTH = 16,
  parameter int DSTRD  = 1,
  localparam int QID_W = (QUEUES > 1) ? $clog2(QUEUES) : 1,
  localparam int PTR_W = (QDEPTH > 2) ? $clog2(QDEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              notifyValid,
  output logic [QID_W-1:0]  notifyQid,
  output logic              notifyIsCq,
  output logic [PTR_W-1:0]  notifyPtr,
  output logic              addrErr,
  output logic              valErr
);

  dbStrobe_t        strobe;
  logic [QID_W-1:0] wrQid, rdQid;
  logic [PTR_W-1:0] wrPtr;

  dbell_ctrl #(
    .ADDR_W(ADDR_W), .QUEUES(QUEUES), .QDEPTH(QDEPTH),
    .DSTRD(DSTRD), .QID_W(QID_W), .PTR_W(PTR_W)
  ) uCtrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .strobe(strobe), .wrQid(wrQid), .wrPtr(wrPtr), .rdQid(rdQid)
  );

  dbell_dpath #(
    .QUEUES(QUEUES), .QDEPTH(QDEPTH), .DSTRD(DSTRD),
    .QID_W(QID_W), .PTR_W(PTR_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrQid(wrQid), .wrPtr(wrPtr), .rdQid(rdQid),
    .rdData(rdData), .rdValid(rdValid),
    .notifyValid(notifyValid), .notifyQid(notifyQid),
    .notifyIsCq(notifyIsCq), .notifyPtr(notifyPtr),
    .addrErr(addrErr), .valErr(valErr)
  );

endmodule

// File: rtl/dbell_checks.sv
module dbell_checks #(
  parameter int ADDR_W = 16,
  parameter int QUEUES = 4,
  parameter int QDEPTH = 16,
  parameter int QID_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic              rdEn,
  input logic              rdValid,
  input logic              notifyValid,
  input logic [QID_W-1:0]  notifyQid,
  input logic              addrErr,
  input logic              valErr
);

  assert_notify_from_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> $past(wrEn));

  assert_notify_queue_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> (32'(notifyQid) < 32'(QUEUES)));

  assert_notify_value_in_depth_R7: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> ($past(wrData) < 32'(QDEPTH)));

  assert_notify_in_region_R8: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> (32'($past(wrAddr)) >= 32'h1000));

  assert_addr_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |=> addrErr);

  assert_val_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    valErr |=> valErr);

  assert_addr_err_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrErr) |-> $past(wrEn));

  assert_read_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn));

  assert_read_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

endmodule

bind dbell_decoder dbell_checks #(
  .ADDR_W(ADDR_W), .QUEUES(QUEUES), .QDEPTH(QDEPTH), .QID_W(QID_W)
) uChecks (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdEn(rdEn), .rdValid(rdValid), .notifyValid(notifyValid),
  .notifyQid(notifyQid), .addrErr(addrErr), .valErr(valErr)
);

// File: tb/tb_dbell_decoder.sv
`timescale 1ns/1ps
module tb_dbell_decoder;

  localparam int ADDR_W = 16;
  localparam int QUEUES = 4;
  localparam int QDEPTH = 16;
  localparam int DSTRD  = 1;
  localparam int STRIDE = 4 << DSTRD;
  localparam int QID_W  = 2;
  localparam int PTR_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0]       wrData = '0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [31:0]       rdData;
  logic              rdValid;
  logic              notifyValid;
  logic [QID_W-1:0]  notifyQid;
  logic              notifyIsCq;
  logic [PTR_W-1:0]  notifyPtr;
  logic              addrErr;
  logic              valErr;

  dbell_decoder #(.ADDR_W(ADDR_W), .QUEUES(QUEUES), .QDEPTH(QDEPTH), .DSTRD(DSTRD)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .notifyValid(notifyValid), .notifyQid(notifyQid), .notifyIsCq(notifyIsCq),
    .notifyPtr(notifyPtr), .addrErr(addrErr), .valErr(valErr)
  );

  always #2.5 clk = ~clk;

  int    tests = 0;
  int    fails = 0;
  int    cycles = 0;
  string tag = "R1";
  string tagQ = "R1";
  bit    started = 0;

  // Behavioural reference model
  int sqM [QUEUES];
  int cqM [QUEUES];
  bit expNv, expC, expAe, expVe, expRv;
  int expQ, expP, expRd;

  // Returns kind: 0 none, 1 valid doorbell, 2 bad address; sets q and cq
  function automatic int classify(int addr, output int q, output int cq);
    int rel, s;
    q = 0; cq = 0;
    if (addr < 'h1000) return 0;
    rel = addr - 'h1000;
    if (rel % STRIDE != 0) return 2;
    s  = rel / STRIDE;
    q  = s / 2;
    cq = s % 2;
    if (q >= QUEUES) return 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    int k, q, cq;
    tagQ = tag;
    if (!rstN) begin
      for (int i = 0; i < QUEUES; i++) begin sqM[i] = 0; cqM[i] = 0; end
      expNv = 0; expC = 0; expQ = 0; expP = 0; expAe = 0; expVe = 0; expRv = 0; expRd = 0;
    end else begin
      expRv = rdEn;
      if (rdEn) begin
        k = classify(int'(rdAddr), q, cq);
        if (int'(rdAddr) == 0)      expRd = QDEPTH - 1;
        else if (int'(rdAddr) == 4) expRd = DSTRD;
        else if (k == 1)            expRd = cq ? cqM[q] : sqM[q];
        else                        expRd = 0;
      end
      expNv = 0;
      if (wrEn) begin
        k = classify(int'(wrAddr), q, cq);
        if (k == 2) expAe = 1;
        else if (k == 1) begin
          if (wrData >= QDEPTH) expVe = 1;
          else begin
            if (cq) cqM[q] = int'(wrData); else sqM[q] = int'(wrData);
            expNv = 1; expQ = q; expC = cq[0]; expP = int'(wrData);
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tagQ, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(notifyValid == expNv, "notifyValid (R2 R3)", int'(notifyValid), int'(expNv));
      if (expNv) begin
        chk(int'(notifyQid) == expQ, "notifyQid (R2)", int'(notifyQid), expQ);
        chk(notifyIsCq == expC, "notifyIsCq (R3)", int'(notifyIsCq), int'(expC));
        chk(int'(notifyPtr) == expP, "notifyPtr (R2)", int'(notifyPtr), expP);
      end
      chk(addrErr == expAe, "addrErr (R5 R6 R10)", int'(addrErr), int'(expAe));
      chk(valErr == expVe, "valErr (R7 R10)", int'(valErr), int'(expVe));
      chk(rdValid == expRv, "rdValid (R9)", int'(rdValid), int'(expRv));
      if (expRv) chk(rdData == 32'(expRd), "rdData (R9)", int'(rdData), expRd);
    end
  end

  task automatic step(bit we, int wa, int wd, bit re, int ra);
    @(negedge clk);
    wrEn = we; wrAddr = ADDR_W'(wa); wrData = 32'(wd);
    rdEn = re; rdAddr = ADDR_W'(ra);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  function automatic int sqAddr(int y); return 'h1000 + 2 * y * STRIDE; endfunction
  function automatic int cqAddr(int y); return 'h1000 + (2 * y + 1) * STRIDE; endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    started = 1;
    // R1: reset state of all pointers and flags
    tag = "R1";
    for (int y = 0; y < QUEUES; y++) begin
      step(0, 0, 0, 1, sqAddr(y));
      step(0, 0, 0, 1, cqAddr(y));
    end
    idle(1);
    // R4: capability read-back and stride
    tag = "R4";
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 4);
    idle(1);
    // R2: submission tails, back to back
    tag = "R2";
    for (int y = 0; y < QUEUES; y++) step(1, sqAddr(y), 3 + y, 0, 0);
    for (int y = 0; y < QUEUES; y++) step(0, 0, 0, 1, sqAddr(y));
    // R3: completion heads
    tag = "R3";
    for (int y = 0; y < QUEUES; y++) step(1, cqAddr(y), 15 - y, 1, sqAddr(y));
    for (int y = 0; y < QUEUES; y++) step(0, 0, 0, 1, cqAddr(y));
    // R8: writes below the doorbell region
    tag = "R8";
    step(1, 'h0010, 7, 0, 0);
    step(1, 'h0FFC, 2, 1, sqAddr(0));
    idle(1);
    // R7: out-of-depth indices
    tag = "R7";
    step(1, sqAddr(1), QDEPTH, 0, 0);
    step(1, cqAddr(2), 40, 1, sqAddr(1));
    step(0, 0, 0, 1, cqAddr(2));
    idle(1);
    // R5: misaligned offsets inside the region
    tag = "R5";
    step(1, 'h1004, 1, 0, 0);
    step(1, 'h1001, 1, 1, 'h1004);
    idle(1);
    // R6: queue id past the implemented count
    tag = "R6";
    step(1, sqAddr(QUEUES), 2, 0, 0);
    step(1, cqAddr(QUEUES + 3), 2, 1, sqAddr(QUEUES));
    idle(1);
    // R10: flags hold with no further errors
    tag = "R10";
    step(1, sqAddr(0), 9, 0, 0);
    idle(4);
    // R9: read and write to the same slot in one cycle
    tag = "R9";
    step(1, sqAddr(2), 11, 1, sqAddr(2));
    step(0, 0, 0, 1, sqAddr(2));
    step(0, 0, 0, 1, 'h0100);
    idle(1);
    // Mixed traffic
    tag = "R9";
    for (int i = 0; i < 1500; i++) begin
      step($urandom_range(0, 1), 'h0FF0 + $urandom_range(0, 'h60), $urandom_range(0, 20),
           $urandom_range(0, 1), 'h0FF0 + $urandom_range(0, 'h60));
    end
    idle(2);
    started = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule